// File: doc/BRIEF.md
# Latched Channel Health Status and Interrupt Controller

This block gathers per-channel fault flags from eight measurement channels and six stimulus channel pairs. Each channel reports three kinds of fault: signal loss, excitation loss and test-accuracy failure. Loss faults must persist for a set number of timebase ticks before they count. A qualified fault clears the channel's bit in a status register. The bit stays cleared until software reads that register. Channels that software has not marked active always read as failed and can never latch a fault.

Each of the six fault classes is one interrupt source. A source sets its latched interrupt status bit when one of its active channels reports a qualified fault, provided the source is enabled. The interrupt line is high whenever an enabled source holds a latched status bit. Measurement loss monitoring pauses while either measurement test mode input is high. Stimulus signal monitoring pauses for pairs configured for 2-wire operation.

A plain single-cycle read/write port gives access to the registers. Read data is registered.

Top module: `fsi_top`

## Requirements
- R1: After reset, every status register, both active-channel registers, the 2-wire register and the interrupt enable register read 0, and `irq` is 0.
- R2: A status bit reads 1 only when its channel is active and has no latched fault. An inactive channel always reads 0. Status addresses 0 to 5 hold, in order: measurement signal, measurement excitation, measurement accuracy, stimulus signal, stimulus excitation, stimulus accuracy. Bit n is channel n.
- R3: A signal-loss or excitation-loss flag latches only after it has been held for PERSIST_TICKS cycles in which `tick` is 1. If the flag drops before then, the count starts again from zero.
- R4: An accuracy-failure flag latches on the first cycle it is seen, even if it lasts only one cycle.
- R5: A latched fault stays visible after the raw flag clears. The next read of that status register returns it and releases it, so a following read shows 1.
- R6: A read made while the qualified fault is still present leaves the bit at 0.
- R7: A fault on an inactive channel latches nothing and raises no interrupt, so the channel reads 1 once it is made active.
- R8: While `meas_offline_test` or `meas_iface_test` is 1, measurement signal and excitation faults do not latch, and their persistence counts restart.
- R9: Stimulus signal faults are ignored for pairs whose bit is 1 in the 2-wire register (address 8). Excitation faults on those pairs are still monitored.
- R10: Interrupt status (address 10) bit k belongs to fault class k, numbered as for the status addresses in R2. A bit latches only if enable bit k (address 9) is 1 when the fault qualifies.
- R11: `irq` is 1 exactly while some latched interrupt status bit has its enable bit set. A read of interrupt status clears it, but a bit whose source fires in the same cycle stays set.
- R12: `reg_rdata` updates on the clock edge that samples `reg_rd` and holds its value otherwise. The configuration registers read back what was written: address 6 measurement active, 7 stimulus active, 8 2-wire, 9 interrupt enable. Addresses 11 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Persistence timebase strobe |
| meas_sig_fault | input | N_MEAS | Raw measurement signal-loss flags |
| meas_exc_fault | input | N_MEAS | Raw measurement excitation-loss flags |
| meas_acc_fault | input | N_MEAS | Raw measurement accuracy-failure flags |
| stim_sig_fault | input | N_STIM | Raw stimulus signal-loss flags |
| stim_exc_fault | input | N_STIM | Raw stimulus excitation-loss flags |
| stim_acc_fault | input | N_STIM | Raw stimulus accuracy-failure flags |
| meas_offline_test | input | 1 | Off-line measurement test running |
| meas_iface_test | input | 1 | Interface measurement test running |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
A persistence counter stuck or cleared at the wrong time shows up as a status bit that drops one tick early or late. The bench sees this at the first read after the threshold tick. A fault latch that releases without a read, or that ignores a read, shows up as a wrong value on the second of two back-to-back reads, two cycles after the fault. A wrong bit order in the interrupt sources, or a missing enable gate, appears on `irq` one cycle after the fault qualifies, and in the interrupt status word on the next read.

// File: rtl/fsi_pkg.sv
package fsi_pkg;

   // fault class index; also the status register address of that class
   localparam int unsigned SRC_MSIG = 0;
   localparam int unsigned SRC_MEXC = 1;
   localparam int unsigned SRC_MACC = 2;
   localparam int unsigned SRC_SSIG = 3;
   localparam int unsigned SRC_SEXC = 4;
   localparam int unsigned SRC_SACC = 5;
   localparam int unsigned NUM_SRC  = 6;

   // configuration and interrupt register addresses
   localparam int unsigned A_MACT  = 6;
   localparam int unsigned A_SACT  = 7;
   localparam int unsigned A_S2W   = 8;
   localparam int unsigned A_IEN   = 9;
   localparam int unsigned A_IST   = 10;

   function automatic int unsigned reg_width(input int unsigned nm, input int unsigned ns);
      int unsigned w;
      w = (nm > ns) ? nm : ns;
      if (w < NUM_SRC) w = NUM_SRC;
      return w;
   endfunction

   function automatic bit is_timed(input int unsigned k);
      return !(k == SRC_MACC || k == SRC_SACC);
   endfunction

endpackage

// File: rtl/fsi_persist.sv
// Per-channel persistence qualifier. LIMIT = 0 gives immediate qualification.
module fsi_persist #(
   parameter int unsigned N     = 8,
   parameter int unsigned LIMIT = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [N-1:0] raw,
   input  logic [N-1:0] hold,
   output logic [N-1:0] qual
);
   localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

   if (N < 1) begin : g_bad_n
      $error("fsi_persist: N must be at least 1");
   end

   for (genvar c = 0; c < N; c++) begin : g_ch
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    cnt_q <= '0;
         else if (!raw[c] || hold[c])   cnt_q <= '0;
         else if (tick && cnt_q != LIM_C) cnt_q <= cnt_q + 1'b1;
      end

      assign qual[c] = raw[c] & ~hold[c] & (cnt_q == LIM_C);
   end

endmodule

// File: rtl/fsi_status_bank.sv
// One status register: sticky failure latch per channel, released by a read.
module fsi_status_bank #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] qual,
   input  logic [N-1:0] active,
   input  logic         clr,
   output logic [N-1:0] status,
   output logic         event_o
);
   logic [N-1:0] fail_q;
   logic [N-1:0] hit;

   assign hit = qual & active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fail_q <= '0;
      else        fail_q <= (fail_q & ~{N{clr}}) | hit;
   end

   assign status  = active & ~fail_q;
   assign event_o = |hit;

endmodule

// File: rtl/fsi_irq.sv
// Latched interrupt status with per-source enable.
module fsi_irq #(
   parameter int unsigned NSRC = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_evt,
   input  logic [NSRC-1:0] en,
   input  logic            clr,
   output logic [NSRC-1:0] stat,
   output logic            irq
);
   logic [NSRC-1:0] stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~{NSRC{clr}}) | (src_evt & en);
   end

   assign stat = stat_q;
   assign irq  = |(stat_q & en);

endmodule

// File: rtl/fsi_top.sv
module fsi_top #(
   parameter int unsigned N_MEAS        = 8,
   parameter int unsigned N_STIM        = 6,
   parameter int unsigned PERSIST_TICKS = 2000,
   parameter int unsigned ADDR_W        = 4
) (
   input  logic                                             clk,
   input  logic                                             rst_n,
   input  logic                                             tick,
   input  logic [N_MEAS-1:0]                                meas_sig_fault,
   input  logic [N_MEAS-1:0]                                meas_exc_fault,
   input  logic [N_MEAS-1:0]                                meas_acc_fault,
   input  logic [N_STIM-1:0]                                stim_sig_fault,
   input  logic [N_STIM-1:0]                                stim_exc_fault,
   input  logic [N_STIM-1:0]                                stim_acc_fault,
   input  logic                                             meas_offline_test,
   input  logic                                             meas_iface_test,
   input  logic                                             reg_wr,
   input  logic                                             reg_rd,
   input  logic [ADDR_W-1:0]                                reg_addr,
   input  logic [fsi_pkg::reg_width(N_MEAS, N_STIM)-1:0]    reg_wdata,
   output logic [fsi_pkg::reg_width(N_MEAS, N_STIM)-1:0]    reg_rdata,
   output logic                                             irq
);
   import fsi_pkg::*;

   localparam int unsigned REG_W = reg_width(N_MEAS, N_STIM);

   if (N_MEAS < 1 || N_STIM < 1) begin : g_bad_ch
      $error("fsi_top: channel counts must be at least 1");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("fsi_top: ADDR_W must be at least 4");
   end
   if (PERSIST_TICKS < 1) begin : g_bad_persist
      $error("fsi_top: PERSIST_TICKS must be at least 1");
   end

   // ---------------- configuration registers ----------------
   logic [N_MEAS-1:0]  meas_act_q;
   logic [N_STIM-1:0]  stim_act_q;
   logic [N_STIM-1:0]  stim_2w_q;
   logic [NUM_SRC-1:0] irq_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meas_act_q <= '0;
         stim_act_q <= '0;
         stim_2w_q  <= '0;
         irq_en_q   <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            ADDR_W'(A_MACT): meas_act_q <= reg_wdata[N_MEAS-1:0];
            ADDR_W'(A_SACT): stim_act_q <= reg_wdata[N_STIM-1:0];
            ADDR_W'(A_S2W):  stim_2w_q  <= reg_wdata[N_STIM-1:0];
            ADDR_W'(A_IEN):  irq_en_q   <= reg_wdata[NUM_SRC-1:0];
            default: ;
         endcase
      end
   end

   // ---------------- fault classes ----------------
   logic               meas_quiet;
   logic [REG_W-1:0]   st_a [NUM_SRC];
   logic [NUM_SRC-1:0] src_evt;
   logic [NUM_SRC-1:0] st_clr;

   assign meas_quiet = meas_offline_test | meas_iface_test;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      localparam bit          IS_MEAS = (k < 3);
      localparam int unsigned W       = IS_MEAS ? N_MEAS : N_STIM;
      localparam int unsigned LIM     = is_timed(k) ? PERSIST_TICKS : 0;

      logic [W-1:0] raw_w, hold_w, act_w, qual_w, st_w;

      if (k == SRC_MSIG) begin : g_in
         assign raw_w  = meas_sig_fault;
         assign hold_w = {W{meas_quiet}};
      end else if (k == SRC_MEXC) begin : g_in
         assign raw_w  = meas_exc_fault;
         assign hold_w = {W{meas_quiet}};
      end else if (k == SRC_MACC) begin : g_in
         assign raw_w  = meas_acc_fault;
         assign hold_w = '0;
      end else if (k == SRC_SSIG) begin : g_in
         assign raw_w  = stim_sig_fault;
         assign hold_w = stim_2w_q;
      end else if (k == SRC_SEXC) begin : g_in
         assign raw_w  = stim_exc_fault;
         assign hold_w = '0;
      end else begin : g_in
         assign raw_w  = stim_acc_fault;
         assign hold_w = '0;
      end

      if (IS_MEAS) begin : g_act
         assign act_w = meas_act_q;
      end else begin : g_act
         assign act_w = stim_act_q;
      end

      assign st_clr[k] = reg_rd && (reg_addr == ADDR_W'(k));

      fsi_persist #(
         .N     (W),
         .LIMIT (LIM)
      ) u_persist (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (tick),
         .raw   (raw_w),
         .hold  (hold_w),
         .qual  (qual_w)
      );

      fsi_status_bank #(
         .N (W)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .qual    (qual_w),
         .active  (act_w),
         .clr     (st_clr[k]),
         .status  (st_w),
         .event_o (src_evt[k])
      );

      assign st_a[k] = REG_W'(st_w);
   end

   // ---------------- interrupt ----------------
   logic [NUM_SRC-1:0] irq_stat;
   logic               irq_clr;

   assign irq_clr = reg_rd && (reg_addr == ADDR_W'(A_IST));

   fsi_irq #(
      .NSRC (NUM_SRC)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_evt (src_evt),
      .en      (irq_en_q),
      .clr     (irq_clr),
      .stat    (irq_stat),
      .irq     (irq)
   );

   // ---------------- read path ----------------
   logic [REG_W-1:0] rd_val;
   logic [REG_W-1:0] rdata_q;
   logic [N_MEAS-1:0] msig_status;

   assign msig_status = st_a[SRC_MSIG][N_MEAS-1:0];

   always_comb begin
      rd_val = '0;
      case (reg_addr)
         ADDR_W'(SRC_MSIG): rd_val = st_a[SRC_MSIG];
         ADDR_W'(SRC_MEXC): rd_val = st_a[SRC_MEXC];
         ADDR_W'(SRC_MACC): rd_val = st_a[SRC_MACC];
         ADDR_W'(SRC_SSIG): rd_val = st_a[SRC_SSIG];
         ADDR_W'(SRC_SEXC): rd_val = st_a[SRC_SEXC];
         ADDR_W'(SRC_SACC): rd_val = st_a[SRC_SACC];
         ADDR_W'(A_MACT):   rd_val = REG_W'(meas_act_q);
         ADDR_W'(A_SACT):   rd_val = REG_W'(stim_act_q);
         ADDR_W'(A_S2W):    rd_val = REG_W'(stim_2w_q);
         ADDR_W'(A_IEN):    rd_val = REG_W'(irq_en_q);
         ADDR_W'(A_IST):    rd_val = REG_W'(irq_stat);
         default:           rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_val;
   end

   assign reg_rdata = rdata_q;

endmodule

// File: rtl/fsi_checker.sv
module fsi_checker #(
   parameter int unsigned N_MEAS = 8,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned REG_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_rd,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [REG_W-1:0]  reg_rdata,
   input logic              irq,
   input logic [5:0]        irq_en_q,
   input logic [5:0]        irq_stat,
   input logic [N_MEAS-1:0] meas_act_q,
   input logic [N_MEAS-1:0] msig_status,
   input logic              meas_offline_test,
   input logic              meas_iface_test
);
   import fsi_pkg::*;

   logic rd_msig, wr_mact;
   assign rd_msig = reg_rd && (reg_addr == ADDR_W'(SRC_MSIG));
   assign wr_mact = reg_wr && (reg_addr == ADDR_W'(A_MACT));

   // inactive channels never report healthy on a status read
   assert_inactive_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_msig |=> ((reg_rdata[N_MEAS-1:0] & ~$past(meas_act_q)) == '0));

   // a failed bit returns to healthy only through a read or an active-mask write
   assert_sticky_until_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_msig && !wr_mact) |=> ((msig_status & ~$past(msig_status)) == '0));

   // no new measurement signal failure while a test mode runs
   assert_quiet_in_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((meas_offline_test || meas_iface_test) && !wr_mact)
         |=> (($past(msig_status) & ~msig_status) == '0));

   // an interrupt status bit can only rise if its enable was set
   assert_enable_gates_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((irq_stat & ~$past(irq_stat) & ~$past(irq_en_q)) == '0));

   // all sources disabled means no request
   assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_q == '0) |-> !irq);

   // read data only moves on a read
   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

endmodule

bind fsi_top fsi_checker #(
   .N_MEAS (N_MEAS),
   .ADDR_W (ADDR_W),
   .REG_W  (REG_W)
) u_fsi_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .reg_rd            (reg_rd),
   .reg_wr            (reg_wr),
   .reg_addr          (reg_addr),
   .reg_rdata         (reg_rdata),
   .irq               (irq),
   .irq_en_q          (irq_en_q),
   .irq_stat          (irq_stat),
   .meas_act_q        (meas_act_q),
   .msig_status       (msig_status),
   .meas_offline_test (meas_offline_test),
   .meas_iface_test   (meas_iface_test)
);

// File: tb/fsi_top_bench.sv
module fsi_top_bench;
   localparam int CLK_P = 10;
   localparam int L     = 3;
   localparam int RW    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic [7:0] m_sig = '0, m_exc = '0, m_acc = '0;
   logic [5:0] s_sig = '0, s_exc = '0, s_acc = '0;
   logic offl = 1'b0, ifct = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [RW-1:0] reg_wdata = '0;
   logic [RW-1:0] reg_rdata;
   logic irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   fsi_top #(
      .N_MEAS(8), .N_STIM(6), .PERSIST_TICKS(L), .ADDR_W(4)
   ) u_fsi_top (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .meas_sig_fault(m_sig), .meas_exc_fault(m_exc), .meas_acc_fault(m_acc),
      .stim_sig_fault(s_sig), .stim_exc_fault(s_exc), .stim_acc_fault(s_acc),
      .meas_offline_test(offl), .meas_iface_test(ifct),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic wr(input int a, input logic [RW-1:0] d);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [RW-1:0] d);
      reg_rd = 1'b1; reg_addr = 4'(a);
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic chk(input logic [RW-1:0] got, input logic [RW-1:0] exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic set_raw(input int k, input int ch, input logic v);
      case (k)
         0: m_sig[ch] = v;
         1: m_exc[ch] = v;
         2: m_acc[ch] = v;
         3: s_sig[ch] = v;
         4: s_exc[ch] = v;
         default: s_acc[ch] = v;
      endcase
   endtask

   function automatic int wid(input int k);
      return (k < 3) ? 8 : 6;
   endfunction

   function automatic logic [RW-1:0] full(input int k);
      return (k < 3) ? 8'hFF : 8'h3F;
   endfunction

   function automatic bit timed(input int k);
      return !(k == 2 || k == 5);
   endfunction

   // leaves fault class k on channel ch latched, raw flag released
   task automatic make_fault(input int k, input int ch);
      set_raw(k, ch, 1'b1);
      if (timed(k)) ticks(L);
      cyc(1);
      set_raw(k, ch, 1'b0);
      cyc(1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R12 watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [RW-1:0] d;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      for (int a = 0; a < 11; a++) begin
         rd(a, d); chk(d, '0, $sformatf("R1 reset value addr %0d", a));
      end
      chk(RW'(irq), '0, "R1 irq after reset");

      // R12 readback and R2 all-active healthy
      wr(6, 8'hFF); wr(7, 8'h3F);
      rd(6, d); chk(d, 8'hFF, "R12 meas active readback");
      rd(7, d); chk(d, 8'h3F, "R12 stim active readback");
      for (int k = 0; k < 6; k++) begin
         rd(k, d); chk(d, full(k), $sformatf("R2 healthy class %0d", k));
      end

      // R3 R5 R6 sweep over the timed classes and every channel
      for (int k = 0; k < 6; k++) begin
         if (timed(k)) begin
            for (int ch = 0; ch < wid(k); ch++) begin
               logic [RW-1:0] bad;
               bad = full(k) & ~(RW'(1) << ch);
               set_raw(k, ch, 1'b1);
               ticks(L - 1); cyc(2);
               rd(k, d); chk(d, full(k), $sformatf("R3 early k%0d ch%0d", k, ch));
               ticks(1); cyc(1);
               rd(k, d); chk(d, bad, $sformatf("R3 threshold k%0d ch%0d", k, ch));
               rd(k, d); chk(d, bad, $sformatf("R6 read while present k%0d ch%0d", k, ch));
               set_raw(k, ch, 1'b0); cyc(1);
               rd(k, d); chk(d, bad, $sformatf("R5 sticky k%0d ch%0d", k, ch));
               rd(k, d); chk(d, full(k), $sformatf("R5 released k%0d ch%0d", k, ch));
            end
         end
      end

      // R3 restart of the count
      set_raw(0, 3, 1'b1); ticks(L - 1);
      set_raw(0, 3, 1'b0); cyc(1);
      set_raw(0, 3, 1'b1); ticks(L - 1); cyc(2);
      rd(0, d); chk(d, 8'hFF, "R3 count restarts after gap");
      set_raw(0, 3, 1'b0); cyc(1);

      // R4 single-cycle accuracy pulses
      for (int k = 2; k < 6; k += 3) begin
         for (int ch = 0; ch < wid(k); ch++) begin
            set_raw(k, ch, 1'b1); cyc(1); set_raw(k, ch, 1'b0); cyc(1);
            rd(k, d); chk(d, full(k) & ~(RW'(1) << ch), $sformatf("R4 pulse k%0d ch%0d", k, ch));
            rd(k, d); chk(d, full(k), $sformatf("R4 release k%0d ch%0d", k, ch));
         end
      end

      // R8 test-mode suppression
      for (int m = 0; m < 2; m++) begin
         offl = (m == 0); ifct = (m == 1);
         m_sig[0] = 1'b1; m_exc[1] = 1'b1;
         ticks(L + 2); cyc(2);
         rd(0, d); chk(d, 8'hFF, $sformatf("R8 signal suppressed mode %0d", m));
         rd(1, d); chk(d, 8'hFF, $sformatf("R8 excitation suppressed mode %0d", m));
      end
      offl = 1'b0; ifct = 1'b0;
      ticks(L - 1); cyc(1);
      rd(0, d); chk(d, 8'hFF, "R8 count restarted after test");
      ticks(1); cyc(1);
      rd(0, d); chk(d, 8'hFE, "R8 monitoring resumes");
      m_sig = '0; m_exc = '0; cyc(1);
      rd(0, d); rd(1, d); rd(0, d); rd(1, d);

      // R9 2-wire pairs
      wr(8, 8'h04);
      rd(8, d); chk(d, 8'h04, "R12 2-wire readback");
      s_sig[2] = 1'b1; s_sig[3] = 1'b1; s_exc[2] = 1'b1;
      ticks(L + 1); cyc(1);
      rd(3, d); chk(d, 8'h37, "R9 signal ignored on 2-wire pair only");
      rd(4, d); chk(d, 8'h3B, "R9 excitation still watched");
      s_sig = '0; s_exc = '0; cyc(1);
      rd(3, d); rd(4, d);
      wr(8, 8'h00);

      // R7 inactive channels
      wr(9, 8'h3F); wr(6, 8'h0F);
      make_fault(2, 5);
      m_sig[6] = 1'b1; ticks(L + 1); cyc(1); m_sig[6] = 1'b0; cyc(1);
      chk(RW'(irq), '0, "R7 no irq from inactive");
      rd(10, d); chk(d, '0, "R7 no interrupt status from inactive");
      rd(2, d); chk(d, 8'h0F, "R7 inactive accuracy reads 0");
      wr(6, 8'hFF);
      rd(2, d); chk(d, 8'hFF, "R7 nothing latched while inactive");
      rd(0, d); chk(d, 8'hFF, "R7 no signal latch while inactive");

      // R10 R11 per-source bit order, masking and clearing
      for (int k = 0; k < 6; k++) begin
         make_fault(k, 0);
         chk(RW'(irq), 8'h01, $sformatf("R11 irq raised class %0d", k));
         wr(9, 8'h00);
         chk(RW'(irq), 8'h00, $sformatf("R11 irq masked class %0d", k));
         wr(9, 8'h3F);
         chk(RW'(irq), 8'h01, $sformatf("R11 irq unmasked class %0d", k));
         rd(10, d); chk(d, RW'(1) << k, $sformatf("R10 source bit class %0d", k));
         chk(RW'(irq), 8'h00, $sformatf("R11 irq cleared class %0d", k));
         rd(k, d); rd(k, d);
      end

      // R10 enable gate
      wr(9, 8'h3E);
      make_fault(0, 1);
      chk(RW'(irq), 8'h00, "R10 disabled source no irq");
      rd(10, d); chk(d, 8'h00, "R10 disabled source not latched");
      wr(9, 8'h3F);
      chk(RW'(irq), 8'h00, "R10 no late latch on enable");
      rd(0, d); rd(0, d);

      // R11 read in the same cycle as an event
      m_acc[2] = 1'b1; cyc(1);
      rd(10, d); chk(d, 8'h04, "R11 first read");
      rd(10, d); chk(d, 8'h04, "R11 set survives read with event");
      m_acc[2] = 1'b0;
      rd(10, d); chk(d, 8'h04, "R11 final latched value");
      rd(10, d); chk(d, 8'h00, "R11 cleared after read");
      chk(RW'(irq), 8'h00, "R11 irq low");
      rd(2, d); rd(2, d);

      // R12 register port
      wr(9, 8'h2A);
      rd(9, d); chk(d, 8'h2A, "R12 enable readback");
      rd(11, d); chk(d, 8'h00, "R12 unused address");
      reg_addr = 4'd9; cyc(3);
      chk(reg_rdata, 8'h00, "R12 rdata holds without read");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule